// File: doc/BRIEF.md
# Predicate-Result Element Sequencer

The sequencer walks the elements of one vector operation, one element per clock, and merges a condition-register test with predication. A start pulse captures the vector length, the predicate mask and the mode controls. The sequencer then presents each element index to an external arithmetic unit and takes back that element's result in the same cycle. For every element that the predicate enables, it derives a 4-bit condition field from the result. Depending on the mode, it records that field in a condition-register slot and writes the result to the destination register.

The result is committed only when one selected bit of the condition field matches an expected value. A compare-only mode records the condition fields and never stores a result. With zeroing enabled, the elements that are masked out and the elements that fail the test both receive an explicit zero in the destination. The arithmetic unit and the register files lie outside the block: the block only issues write strobes, indices and data.

Top module: `predResultSeq`

## Requirements
- R1: After reset, regWe, crWe, done and elemValid are all 0.
- R2: A start pulse taken while idle latches a length of min(vlIn, MAX_VL). Elements 0 to length-1 are then presented on elemIdx with elemValid=1, one per cycle. The write strobes for element i appear in the cycle after element i is presented.
- R3: done is a single-cycle pulse. It coincides with the write strobes of the last element. With a length of 0, done appears in the cycle after the start pulse and there are no writes.
- R4: When predValid=0 at start, every element is enabled; otherwise element i is enabled when predMask[i]=1. An element that is not enabled causes no CR write. It also causes no register write unless zeroing is on.
- R5: The condition field holds lt at bit 3, gt at bit 2, eq at bit 1 and so at bit 0. lt and gt are the signed comparison of the result with zero, eq means the result is zero, and so is always 0.
- R6: For an enabled element, crWe=1 exactly when rcEn=1 or cmpOnly=1. crIdx is then CR_BASE+i (8 by default) and crData is the condition field.
- R7: crSel=s selects bit s of the condition field (0 so, 1 eq, 2 gt, 3 lt). An enabled element writes resData to regIdx=i only when that bit equals expectBit and cmpOnly=0.
- R8: With cmpOnly=1, regWe stays 0 for every element, even with zeroing on.
- R9: With zeroFill=1 and cmpOnly=0, a masked-out element or an element that fails the test produces regWe=1 with regData=0 at regIdx=i.
- R10: Changes to the configuration inputs, and start pulses, while a sequence is running have no effect on that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| vlIn | input | VLW | Requested vector length |
| predValid | input | 1 | 1: use predMask, 0: all elements enabled |
| predMask | input | MAX_VL | Per-element enable mask |
| rcEn | input | 1 | Record condition fields |
| cmpOnly | input | 1 | Compare-only mode: record fields, never store results |
| crSel | input | 2 | Condition-field bit to test |
| expectBit | input | 1 | Value the tested bit must have to commit |
| zeroFill | input | 1 | Write zero for masked-out or failing elements |
| resData | input | XLEN | Result of the element shown on elemIdx |
| elemValid | output | 1 | An element is being presented |
| elemIdx | output | IW | Index of the presented element |
| regWe | output | 1 | Destination register write strobe |
| regIdx | output | IW | Destination element index |
| regData | output | XLEN | Destination write data |
| crWe | output | 1 | Condition field write strobe |
| crIdx | output | CRW | Condition field slot index |
| crData | output | 4 | Condition field value |
| done | output | 1 | Sequence complete pulse |

## Verification
The bench targets a zero result, where eq is set and neither lt nor gt may be, and values at the sign boundary. A design that compares unsigned would report gt for negative values and commit the wrong elements. Compare-only runs with zeroing on catch a design that lets the zero fill leak into the registers. All-masked runs with zeroing catch one that skips the fill or records condition fields for disabled elements. A length of zero and a request above MAX_VL check the timing of done and the clamp. Start pulses and altered configuration injected mid-run catch a design that restarts or samples the mode inputs live.

// File: rtl/predResultPkg.sv
package predResultPkg;

  // Bit positions inside the 4-bit condition field.
  localparam int unsigned CF_SO = 0;
  localparam int unsigned CF_EQ = 1;
  localparam int unsigned CF_GT = 2;
  localparam int unsigned CF_LT = 3;

  // Mode settings latched at start and held for the whole sequence.
  typedef struct packed {
    logic       rcEn;
    logic       cmpOnly;
    logic       zeroFill;
    logic       expectBit;
    logic [1:0] crSel;
  } modeCfgT;

  // Per-cycle strobes from control to datapath.
  typedef struct packed {
    logic step;    // an element is processed this cycle
    logic last;    // it is the final element
    logic active;  // predicate enables it
  } ctrlStrobeT;

endpackage

// File: rtl/predResultCtrl.sv
module predResultCtrl
  import predResultPkg::*;
#(
  parameter int MAX_VL = 8,
  localparam int VLW = $clog2(MAX_VL + 1),
  localparam int IW  = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [VLW-1:0]    vlIn,
  input  logic              predValid,
  input  logic [MAX_VL-1:0] predMask,
  input  modeCfgT           cfgIn,
  output modeCfgT           cfgQ,
  output ctrlStrobeT        strobe,
  output logic [IW-1:0]     idxQ,
  output logic              busyQ,
  output logic              doneQ
);

  logic [VLW-1:0]    vlQ;
  logic [MAX_VL-1:0] maskQ;
  logic [VLW-1:0]    vlEff;
  logic [MAX_VL-1:0] maskEff;
  logic              isLast;

  always_comb begin
    if (vlIn > VLW'(MAX_VL)) vlEff = VLW'(MAX_VL);
    else                     vlEff = vlIn;
    maskEff = predValid ? predMask : {MAX_VL{1'b1}};
  end

  assign isLast = busyQ && (VLW'(idxQ) == vlQ - VLW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      idxQ  <= '0;
      vlQ   <= '0;
      maskQ <= '0;
      cfgQ  <= '0;
    end else if (busyQ) begin
      doneQ <= isLast;
      if (isLast) busyQ <= 1'b0;
      else        idxQ  <= idxQ + IW'(1);
    end else if (start) begin
      vlQ   <= vlEff;
      maskQ <= maskEff;
      cfgQ  <= cfgIn;
      idxQ  <= '0;
      busyQ <= (vlEff != '0);
      doneQ <= (vlEff == '0);
    end else begin
      doneQ <= 1'b0;
    end
  end

  always_comb begin
    strobe.step   = busyQ;
    strobe.last   = isLast;
    strobe.active = busyQ && maskQ[idxQ];
  end

  assert_idx_in_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (VLW'(idxQ) < vlQ));
  assert_done_when_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> !busyQ);
  assert_cfg_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && $past(busyQ)) |-> $stable(cfgQ));

endmodule

// File: rtl/predResultData.sv
module predResultData
  import predResultPkg::*;
#(
  parameter int XLEN    = 16,
  parameter int MAX_VL  = 8,
  parameter int CRW     = 7,
  parameter int CR_BASE = 8,
  localparam int IW = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strobe,
  input  modeCfgT          cfg,
  input  logic [IW-1:0]    idx,
  input  logic [XLEN-1:0]  resData,
  output logic             regWe,
  output logic [IW-1:0]    regIdx,
  output logic [XLEN-1:0]  regData,
  output logic             crWe,
  output logic [CRW-1:0]   crIdx,
  output logic [3:0]       crData
);

  logic [3:0] condField;
  logic       testBit;
  logic       passTest;
  logic       commitRes;
  logic       fillZero;
  logic       recordCf;

  // Condition field of the current element.
  always_comb begin
    condField        = '0;
    condField[CF_EQ] = (resData == '0);
    condField[CF_LT] = resData[XLEN-1];
    condField[CF_GT] = !resData[XLEN-1] && (resData != '0);
    condField[CF_SO] = 1'b0;
  end

  always_comb begin
    testBit   = condField[cfg.crSel];
    passTest  = (testBit == cfg.expectBit);
    commitRes = strobe.step && strobe.active && passTest && !cfg.cmpOnly;
    fillZero  = strobe.step && cfg.zeroFill && !cfg.cmpOnly &&
                (!strobe.active || !passTest);
    recordCf  = strobe.step && strobe.active && (cfg.rcEn || cfg.cmpOnly);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regWe   <= 1'b0;
      regIdx  <= '0;
      regData <= '0;
      crWe    <= 1'b0;
      crIdx   <= '0;
      crData  <= '0;
    end else begin
      regWe <= commitRes || fillZero;
      crWe  <= recordCf;
      if (strobe.step) begin
        regIdx  <= idx;
        regData <= commitRes ? resData : '0;
        crIdx   <= CRW'(CR_BASE) + CRW'(idx);
        crData  <= condField;
      end
    end
  end

  assert_cmp_only_no_reg_R8: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> !$past(cfg.cmpOnly));
  assert_masked_no_cr_R4: assert property (@(posedge clk) disable iff (!rstN)
    crWe |-> $past(strobe.active));
  assert_fill_is_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !$past(strobe.active)) |-> (regData == '0));
  assert_cr_slot_R6: assert property (@(posedge clk) disable iff (!rstN)
    crWe |-> (crIdx == CRW'(CR_BASE) + CRW'($past(idx))));
  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    crWe |-> ($countones(crData[3:1]) == 1));

endmodule

// File: rtl/predResultSeq.sv
module predResultSeq
  import predResultPkg::*;
#(
  parameter int XLEN    = 16,
  parameter int MAX_VL  = 8,
  parameter int CRW     = 7,
  parameter int CR_BASE = 8,
  localparam int VLW = $clog2(MAX_VL + 1),
  localparam int IW  = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [VLW-1:0]    vlIn,
  input  logic              predValid,
  input  logic [MAX_VL-1:0] predMask,
  input  logic              rcEn,
  input  logic              cmpOnly,
  input  logic [1:0]        crSel,
  input  logic              expectBit,
  input  logic              zeroFill,
  input  logic [XLEN-1:0]   resData,
  output logic              elemValid,
  output logic [IW-1:0]     elemIdx,
  output logic              regWe,
  output logic [IW-1:0]     regIdx,
  output logic [XLEN-1:0]   regData,
  output logic              crWe,
  output logic [CRW-1:0]    crIdx,
  output logic [3:0]        crData,
  output logic              done
);

  modeCfgT    cfgIn;
  modeCfgT    cfgQ;
  ctrlStrobeT strobe;
  logic [IW-1:0] idxQ;
  logic          busyQ;
  logic          doneQ;

  always_comb begin
    cfgIn.rcEn      = rcEn;
    cfgIn.cmpOnly   = cmpOnly;
    cfgIn.zeroFill  = zeroFill;
    cfgIn.expectBit = expectBit;
    cfgIn.crSel     = crSel;
  end

  predResultCtrl #(.MAX_VL(MAX_VL)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .vlIn(vlIn),
    .predValid(predValid), .predMask(predMask), .cfgIn(cfgIn),
    .cfgQ(cfgQ), .strobe(strobe), .idxQ(idxQ), .busyQ(busyQ), .doneQ(doneQ)
  );

  predResultData #(.XLEN(XLEN), .MAX_VL(MAX_VL), .CRW(CRW), .CR_BASE(CR_BASE)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfg(cfgQ), .idx(idxQ),
    .resData(resData), .regWe(regWe), .regIdx(regIdx), .regData(regData),
    .crWe(crWe), .crIdx(crIdx), .crData(crData)
  );

  assign elemValid = busyQ;
  assign elemIdx   = idxQ;
  assign done      = doneQ;

endmodule

// File: tb/sim_predResultSeq.sv
`timescale 1ns/1ps
module sim_predResultSeq;

  localparam int XLEN = 16;
  localparam int MAX_VL = 8;
  localparam int CRW = 7;
  localparam int CR_BASE = 8;
  localparam int VLW = $clog2(MAX_VL + 1);
  localparam int IW = $clog2(MAX_VL);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [VLW-1:0] vlIn = '0;
  logic predValid = 1'b0;
  logic [MAX_VL-1:0] predMask = '0;
  logic rcEn = 1'b0, cmpOnly = 1'b0, expectBit = 1'b0, zeroFill = 1'b0;
  logic [1:0] crSel = '0;
  logic [XLEN-1:0] resData;
  logic elemValid, regWe, crWe, done;
  logic [IW-1:0] elemIdx, regIdx;
  logic [XLEN-1:0] regData;
  logic [CRW-1:0] crIdx;
  logic [3:0] crData;

  logic [XLEN-1:0] resArr [MAX_VL];
  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;
  assign resData = resArr[elemIdx];

  predResultSeq #(.XLEN(XLEN), .MAX_VL(MAX_VL), .CRW(CRW), .CR_BASE(CR_BASE)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .vlIn(vlIn), .predValid(predValid),
    .predMask(predMask), .rcEn(rcEn), .cmpOnly(cmpOnly), .crSel(crSel),
    .expectBit(expectBit), .zeroFill(zeroFill), .resData(resData),
    .elemValid(elemValid), .elemIdx(elemIdx), .regWe(regWe), .regIdx(regIdx),
    .regData(regData), .crWe(crWe), .crIdx(crIdx), .crData(crData), .done(done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  function automatic logic [3:0] refField(input logic [XLEN-1:0] r);
    logic signed [XLEN-1:0] s;
    s = r;
    return {s < 0, s > 0, s == 0, 1'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One sequence; rcV etc. are the values latched at start.
  task automatic runSeq(input int vl, input logic pv, input logic [MAX_VL-1:0] mask,
                        input logic rcV, input logic c1V, input logic [1:0] selV,
                        input logic expV, input logic zV, input logic scramble);
    int effVl;
    effVl = (vl > MAX_VL) ? MAX_VL : vl;
    @(negedge clk);
    vlIn = VLW'(vl); predValid = pv; predMask = mask; rcEn = rcV; cmpOnly = c1V;
    crSel = selV; expectBit = expV; zeroFill = zV; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 no write right after start", {30'd0, regWe, crWe}, 32'd0);
    chk("R3 done after start", {31'd0, done}, {31'd0, effVl == 0});
    chk("R2 elemValid after start", {31'd0, elemValid}, {31'd0, effVl != 0});
    for (int i = 0; i < effVl; i++) begin
      if (scramble) begin  // R10 mid-run changes must be ignored
        vlIn = VLW'($urandom_range(0, 15)); predValid = 1'($urandom);
        predMask = MAX_VL'($urandom); rcEn = 1'($urandom); cmpOnly = 1'($urandom);
        crSel = 2'($urandom); expectBit = 1'($urandom); zeroFill = 1'($urandom);
        start = (i < effVl - 1) ? 1'($urandom) : 1'b0;
      end
      chk("R2 presented index", {29'd0, elemIdx}, i);
      @(negedge clk);
      start = 1'b0;
      begin
        logic act, pass, eCr, eReg;
        logic [3:0] f;
        f = refField(resArr[i]);
        act = !pv || mask[i];
        pass = (f[selV] == expV);
        eCr = act && (rcV || c1V);
        eReg = !c1V && ((act && pass) || (zV && !(act && pass)));
        chk("R6 R4 crWe", {31'd0, crWe}, {31'd0, eCr});
        if (eCr) begin
          chk("R6 crIdx", {25'd0, crIdx}, CR_BASE + i);
          chk("R5 crData", {28'd0, crData}, {28'd0, f});
        end
        chk("R7 R8 R9 regWe", {31'd0, regWe}, {31'd0, eReg});
        if (eReg) begin
          chk("R7 regIdx", {29'd0, regIdx}, i);
          chk("R7 R9 regData", {16'd0, regData}, {16'd0, (act && pass) ? resArr[i] : 16'd0});
        end
        chk("R3 done pulse", {31'd0, done}, {31'd0, i == effVl - 1});
      end
    end
    @(negedge clk);
    chk("R3 R10 idle after sequence", {29'd0, regWe, crWe, done}, 32'd0);
    chk("R10 not restarted", {31'd0, elemValid}, 32'd0);
  endtask

  function automatic logic [XLEN-1:0] pickRes();
    case ($urandom_range(0, 4))
      0: return '0;
      1: return 16'h8000;
      2: return 16'h7fff;
      3: return 16'hffff;
      default: return XLEN'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < MAX_VL; k++) resArr[k] = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {28'd0, regWe, crWe, done, elemValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {28'd0, regWe, crWe, done, elemValid}, 32'd0);

    // Directed: zero, positive, negative, min, max; test eq==1 with record
    resArr[0] = 16'h0000; resArr[1] = 16'h0001; resArr[2] = 16'hffff;
    resArr[3] = 16'h8000; resArr[4] = 16'h7fff; resArr[5] = 16'h0000;
    resArr[6] = 16'h0042; resArr[7] = 16'hfff0;
    runSeq(8, 1'b0, '0, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0);   // R5 R7 eq select
    runSeq(8, 1'b0, '0, 1'b1, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0);   // R9 lt select with fill
    runSeq(8, 1'b0, '0, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0);   // R7 gt==0
    runSeq(8, 1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);   // R7 so always 0, no CR
    runSeq(8, 1'b0, '0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0);   // R8 compare only + fill
    runSeq(8, 1'b1, '0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0);   // R4 R9 all masked, fill
    runSeq(8, 1'b1, '0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);   // R4 all masked, no fill
    runSeq(8, 1'b1, 8'b1010_0110, 1'b1, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0); // R4 R9
    runSeq(0, 1'b0, '0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0);   // R3 zero length
    runSeq(12, 1'b0, '0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);  // R2 clamp
    runSeq(1, 1'b0, '0, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1);   // R3 single element
    runSeq(8, 1'b1, 8'h5a, 1'b1, 1'b0, 2'd2, 1'b1, 1'b1, 1'b1); // R10 scramble

    // Constrained random
    for (int t = 0; t < 60; t++) begin
      for (int k = 0; k < MAX_VL; k++) resArr[k] = pickRes();
      runSeq($urandom_range(0, 9), 1'($urandom), MAX_VL'($urandom), 1'($urandom),
             ($urandom_range(0, 3) == 0), 2'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule